// File: doc/BRIEF.md
# Beat-Sequenced Instruction Control Unit

This block is the control half of a small 16-bit accumulator machine. It holds the program counter, the instruction register, a memory address register, a beat counter, a latched per-instruction flag and an eight-entry return-address stack. The program is a read-only array inside the block, filled from a packed parameter image. Each instruction word carries a 5-bit opcode in bits [15:11] and an 11-bit address or operand field in bits [10:0].

Every instruction runs as a fixed sequence of beats, one beat per clock. Beat 0 fetches the word. Beat 1 decodes it. The later beats emit register-transfer strobes for the accumulator, the operand registers, the output register and the data RAM. The arithmetic datapath sits outside the block. It consumes the strobes and the instruction register, and it returns two flags: one says the accumulator is zero, the other is the accumulator's sign bit. When the last beat of an instruction has run, the beat counter returns to zero. A halt opcode stops the counter until the next reset.

Top module: `beat_seq_ctrl`

## Requirements
- R1: A synchronous reset sets the PC, IR, MAR, beat counter, instruction flag and stack pointer to zero, and it clears the halted state.
- R2: In beat 0, irLoad is high and IR is loaded with ROM word PC. ROM word i occupies bits [16i+15:16i] of the image parameter. The beat then advances to 1.
- R3: LDA (00001), OUT (00011) and STR (00110) load MAR from IR[10:0] in beat 1 and increment PC in beat 2. In beat 3 they pulse daLoadRam, outLoadRam or ramWrite respectively. Each takes 5 cycles.
- R4: ADD (00010), SUB (00111), MULT (01101) and DIVI (01110) use beats 1 and 2 in the same way as R3. Beat 3 pulses bLoadRam, beat 4 pulses aLoadDa and beat 5 pulses resultWrite. MULT and DIVI also pulse outLoadResult in beat 5. aluOp reads 0, 1, 2 or 3 respectively from beat 2 through beat 6. Each takes 7 cycles.
- R5: SDAL (00100) and SDAH (00101) increment PC in beat 1. In beat 2 they pulse daLoadLo or daLoadHi respectively; the datapath takes the byte from IR[7:0]. Each takes 4 cycles.
- R6: JMP (01000) loads PC from IR[10:0] in beat 1 and takes 3 cycles.
- R7: JZ (01001) loads PC from IR[10:0] when accZero is 1, and JN (01010) does so when accSign is 1. Otherwise PC increments. Both take 3 cycles.
- R8: CALL (01011) pushes PC+1 in beat 1, loads PC from IR[10:0] in beat 2 and advances the stack pointer in beat 3. RET (01100) moves the pointer back in beat 1 and loads PC from the stack in beat 2. Each takes 4 cycles, and calls nest.
- R9: After STP (11111) is decoded, halted stays high and the beat stays at 0. PC and IR hold, and no strobe fires until reset.
- R10: Any other opcode increments PC in beat 1, fires no transfer strobe and takes 3 cycles.
- R11: In any cycle, at most one of daLoadRam, daLoadLo, daLoadHi and resultWrite is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| accZero | input | 1 | Accumulator equals zero |
| accSign | input | 1 | Accumulator most significant bit |
| pcOut | output | 11 | Program counter |
| irOut | output | 16 | Instruction register |
| marOut | output | 11 | Memory address register |
| beatOut | output | 3 | Current beat |
| irLoad | output | 1 | Fetch beat strobe |
| daLoadRam | output | 1 | Accumulator takes RAM data |
| daLoadLo | output | 1 | Accumulator low byte takes IR[7:0] |
| daLoadHi | output | 1 | Accumulator high byte takes IR[7:0] |
| bLoadRam | output | 1 | Operand B takes RAM data |
| aLoadDa | output | 1 | Operand A takes accumulator |
| resultWrite | output | 1 | Accumulator takes ALU result |
| aluOp | output | 2 | ALU function: add, sub, mul, div |
| outLoadRam | output | 1 | Output register takes RAM data |
| outLoadResult | output | 1 | Output register takes ALU high part or remainder |
| ramWrite | output | 1 | Data RAM writes accumulator at MAR |
| halted | output | 1 | Machine stopped |

## Verification
The bench builds the block with a 32-word ROM and an 8-entry stack. The ROM image it passes in exercises every opcode class, a two-level nested call, both conditional jumps and a word with an opcode the block does not recognise. The same image runs three times under different accZero and accSign settings. Across the runs JZ is both taken and not taken, and so is JN. Each run ends in a halt, and the next run's reset clears it.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 5;
  localparam int ADDR_W = WORD_W - OPC_W;
  localparam int BEAT_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NONE = 5'b00000,
    OP_LDA  = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_OUT  = 5'b00011,
    OP_SDAL = 5'b00100,
    OP_SDAH = 5'b00101,
    OP_STR  = 5'b00110,
    OP_SUB  = 5'b00111,
    OP_JMP  = 5'b01000,
    OP_JZ   = 5'b01001,
    OP_JN   = 5'b01010,
    OP_CALL = 5'b01011,
    OP_RET  = 5'b01100,
    OP_MULT = 5'b01101,
    OP_DIVI = 5'b01110,
    OP_STP  = 5'b11111
  } opcode_t;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV} aluOp_t;

  // strobes from control to the address-side datapath
  typedef struct packed {
    logic irLoad;
    logic marLoad;
    logic pcInc;
    logic pcJump;
    logic pcPop;
    logic stackPush;
    logic spInc;
    logic spDec;
  } seqStrobe_t;

  // strobes leaving the block toward the arithmetic datapath
  typedef struct packed {
    logic daLoadRam;
    logic daLoadLo;
    logic daLoadHi;
    logic bLoadRam;
    logic aLoadDa;
    logic resultWrite;
    logic outLoadRam;
    logic outLoadResult;
    logic ramWrite;
  } xferStrobe_t;

  function automatic logic isAluOp(opcode_t op);
    return op inside {OP_ADD, OP_SUB, OP_MULT, OP_DIVI};
  endfunction

  function automatic logic isMemOp(opcode_t op);
    return isAluOp(op) || (op inside {OP_LDA, OP_OUT, OP_STR});
  endfunction

  function automatic logic [BEAT_W-1:0] lastBeat(opcode_t op);
    if (isAluOp(op)) return BEAT_W'(6);
    if (op inside {OP_LDA, OP_OUT, OP_STR}) return BEAT_W'(4);
    if (op inside {OP_SDAL, OP_SDAH, OP_CALL, OP_RET}) return BEAT_W'(3);
    return BEAT_W'(2);
  endfunction
endpackage

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import beat_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  opcode_t           decOp,
  input  logic              accZero,
  input  logic              accSign,
  output seqStrobe_t        seq,
  output xferStrobe_t       xfer,
  output aluOp_t            aluSel,
  output logic [BEAT_W-1:0] beat,
  output logic              halted
);
  opcode_t           flagOp;
  logic [BEAT_W-1:0] beatNext;
  logic              setFlag;
  logic              clrFlag;
  logic              haltSet;

  always_comb begin
    seq      = '0;
    xfer     = '0;
    beatNext = beat + 1'b1;
    setFlag  = 1'b0;
    clrFlag  = 1'b0;
    haltSet  = 1'b0;
    if (halted) begin
      beatNext = '0;
    end else if (beat == '0) begin
      seq.irLoad = 1'b1;
    end else if (beat == BEAT_W'(1)) begin
      case (decOp)
        OP_LDA, OP_OUT, OP_STR, OP_ADD, OP_SUB, OP_MULT, OP_DIVI: begin
          seq.marLoad = 1'b1;
          setFlag     = 1'b1;
        end
        OP_SDAL, OP_SDAH: begin
          seq.pcInc = 1'b1;
          setFlag   = 1'b1;
        end
        OP_JMP: seq.pcJump = 1'b1;
        OP_JZ: begin
          seq.pcJump = accZero;
          seq.pcInc  = !accZero;
        end
        OP_JN: begin
          seq.pcJump = accSign;
          seq.pcInc  = !accSign;
        end
        OP_CALL: begin
          seq.stackPush = 1'b1;
          setFlag       = 1'b1;
        end
        OP_RET: begin
          seq.spDec = 1'b1;
          setFlag   = 1'b1;
        end
        OP_STP: begin
          haltSet  = 1'b1;
          beatNext = '0;
        end
        default: seq.pcInc = 1'b1;
      endcase
    end else begin
      if (beat == lastBeat(flagOp)) begin
        beatNext = '0;
        clrFlag  = 1'b1;
      end
      if (isMemOp(flagOp) && beat == BEAT_W'(2)) seq.pcInc = 1'b1;
      case (flagOp)
        OP_LDA:  xfer.daLoadRam  = (beat == BEAT_W'(3));
        OP_OUT:  xfer.outLoadRam = (beat == BEAT_W'(3));
        OP_STR:  xfer.ramWrite   = (beat == BEAT_W'(3));
        OP_ADD, OP_SUB, OP_MULT, OP_DIVI: begin
          xfer.bLoadRam      = (beat == BEAT_W'(3));
          xfer.aLoadDa       = (beat == BEAT_W'(4));
          xfer.resultWrite   = (beat == BEAT_W'(5));
          xfer.outLoadResult = (beat == BEAT_W'(5)) &&
                               (flagOp == OP_MULT || flagOp == OP_DIVI);
        end
        OP_SDAL: xfer.daLoadLo = (beat == BEAT_W'(2));
        OP_SDAH: xfer.daLoadHi = (beat == BEAT_W'(2));
        OP_CALL: begin
          seq.pcJump = (beat == BEAT_W'(2));
          seq.spInc  = (beat == BEAT_W'(3));
        end
        OP_RET:  seq.pcPop = (beat == BEAT_W'(2));
        default: ;
      endcase
    end
  end

  always_comb begin
    case (flagOp)
      OP_SUB:  aluSel = ALU_SUB;
      OP_MULT: aluSel = ALU_MUL;
      OP_DIVI: aluSel = ALU_DIV;
      default: aluSel = ALU_ADD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat   <= '0;
      flagOp <= OP_NONE;
      halted <= 1'b0;
    end else begin
      beat <= beatNext;
      if (haltSet) halted <= 1'b1;
      if (setFlag) flagOp <= decOp;
      else if (clrFlag) flagOp <= OP_NONE;
    end
  end
endmodule

// File: rtl/addr_path.sv
module addr_path
  import beat_seq_pkg::*;
#(
  parameter int ROM_DEPTH   = 32,
  parameter int STACK_DEPTH = 8,
  parameter logic [ROM_DEPTH*WORD_W-1:0] PROG_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        seq,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] ir,
  output logic [ADDR_W-1:0] mar
);
  localparam int ROM_AW = $clog2(ROM_DEPTH);
  localparam int SP_W   = $clog2(STACK_DEPTH);

  logic [WORD_W-1:0] romArr [ROM_DEPTH];
  logic [ADDR_W-1:0] retStack [STACK_DEPTH];
  logic [SP_W-1:0]   sp;
  logic [ADDR_W-1:0] pcPlus;
  logic [WORD_W-1:0] romWord;

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    assign romArr[i] = PROG_IMAGE[i*WORD_W +: WORD_W];
  end

  assign romWord = romArr[pc[ROM_AW-1:0]];
  assign pcPlus  = pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      sp  <= '0;
    end else begin
      if (seq.irLoad)  ir  <= romWord;
      if (seq.marLoad) mar <= ir[ADDR_W-1:0];
      if (seq.pcJump)      pc <= ir[ADDR_W-1:0];
      else if (seq.pcPop)  pc <= retStack[sp];
      else if (seq.pcInc)  pc <= pcPlus;
      if (seq.spInc)      sp <= sp + 1'b1;
      else if (seq.spDec) sp <= sp - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (seq.stackPush) retStack[sp] <= pcPlus;
  end
endmodule

// File: rtl/beat_seq_ctrl.sv
module beat_seq_ctrl
  import beat_seq_pkg::*;
#(
  parameter int ROM_DEPTH   = 32,
  parameter int STACK_DEPTH = 8,
  parameter logic [ROM_DEPTH*WORD_W-1:0] PROG_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accZero,
  input  logic              accSign,
  output logic [ADDR_W-1:0] pcOut,
  output logic [WORD_W-1:0] irOut,
  output logic [ADDR_W-1:0] marOut,
  output logic [BEAT_W-1:0] beatOut,
  output logic              irLoad,
  output logic              daLoadRam,
  output logic              daLoadLo,
  output logic              daLoadHi,
  output logic              bLoadRam,
  output logic              aLoadDa,
  output logic              resultWrite,
  output logic [1:0]        aluOp,
  output logic              outLoadRam,
  output logic              outLoadResult,
  output logic              ramWrite,
  output logic              halted
);
  seqStrobe_t  seq;
  xferStrobe_t xfer;
  aluOp_t      aluSel;
  opcode_t     decOp;

  assign decOp = opcode_t'(irOut[WORD_W-1:ADDR_W]);

  beat_ctrl u_ctrl (
    .clk(clk), .rst(rst), .decOp(decOp), .accZero(accZero), .accSign(accSign),
    .seq(seq), .xfer(xfer), .aluSel(aluSel), .beat(beatOut), .halted(halted)
  );

  addr_path #(
    .ROM_DEPTH(ROM_DEPTH), .STACK_DEPTH(STACK_DEPTH), .PROG_IMAGE(PROG_IMAGE)
  ) u_path (
    .clk(clk), .rst(rst), .seq(seq), .pc(pcOut), .ir(irOut), .mar(marOut)
  );

  assign irLoad        = seq.irLoad;
  assign daLoadRam     = xfer.daLoadRam;
  assign daLoadLo      = xfer.daLoadLo;
  assign daLoadHi      = xfer.daLoadHi;
  assign bLoadRam      = xfer.bLoadRam;
  assign aLoadDa       = xfer.aLoadDa;
  assign resultWrite   = xfer.resultWrite;
  assign outLoadRam    = xfer.outLoadRam;
  assign outLoadResult = xfer.outLoadResult;
  assign ramWrite      = xfer.ramWrite;
  assign aluOp         = aluSel;
endmodule

// File: rtl/beat_seq_chk.sv
module beat_seq_chk
  import beat_seq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              accSign,
  input logic [WORD_W-1:0] irOut,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] marOut,
  input logic [BEAT_W-1:0] beatOut,
  input logic              halted,
  input logic              irLoad,
  input logic              daLoadRam,
  input logic              daLoadLo,
  input logic              daLoadHi,
  input logic              resultWrite
);
  opcode_t curOp;
  assign curOp = opcode_t'(irOut[WORD_W-1:ADDR_W]);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pcOut == '0 && beatOut == '0 && !halted && irOut == '0));

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    irLoad |=> beatOut == BEAT_W'(1));

  a_r3_mar_capture: assert property (@(posedge clk) disable iff (rst)
    (beatOut == BEAT_W'(1) && !halted && isMemOp(curOp)) |=> marOut == $past(irOut[ADDR_W-1:0]));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    (beatOut == BEAT_W'(1) && !halted && curOp == OP_JMP) |=> pcOut == $past(irOut[ADDR_W-1:0]));

  a_r7_sign_branch: assert property (@(posedge clk) disable iff (rst)
    (beatOut == BEAT_W'(1) && !halted && curOp == OP_JN && accSign) |=> pcOut == $past(irOut[ADDR_W-1:0]));

  a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && beatOut == '0 && $stable(pcOut) && $stable(irOut) && !irLoad));

  a_r11_single_da: assert property (@(posedge clk) disable iff (rst)
    $onehot0({daLoadRam, daLoadLo, daLoadHi, resultWrite}));
endmodule

bind beat_seq_ctrl beat_seq_chk u_chk (
  .clk(clk), .rst(rst), .accSign(accSign), .irOut(irOut), .pcOut(pcOut),
  .marOut(marOut), .beatOut(beatOut), .halted(halted), .irLoad(irLoad),
  .daLoadRam(daLoadRam), .daLoadLo(daLoadLo), .daLoadHi(daLoadHi),
  .resultWrite(resultWrite)
);

// File: tb/sim_beat_seq_ctrl.sv
`timescale 1ns/1ps
module sim_beat_seq_ctrl;
  localparam int DEPTH = 32;

  function automatic logic [DEPTH*16-1:0] buildImage();
    logic [DEPTH*16-1:0] img;
    img = '0;
    img[0*16 +: 16]  = 16'h2034; // SDAL 0x34
    img[1*16 +: 16]  = 16'h2812; // SDAH 0x12
    img[2*16 +: 16]  = 16'h0805; // LDA 5
    img[3*16 +: 16]  = 16'h1006; // ADD 6
    img[4*16 +: 16]  = 16'h3807; // SUB 7
    img[5*16 +: 16]  = 16'h6808; // MULT 8
    img[6*16 +: 16]  = 16'h7009; // DIVI 9
    img[7*16 +: 16]  = 16'h180A; // OUT 10
    img[8*16 +: 16]  = 16'h300B; // STR 11
    img[9*16 +: 16]  = 16'h5814; // CALL 20
    img[10*16 +: 16] = 16'h480D; // JZ 13
    img[11*16 +: 16] = 16'h500E; // JN 14
    img[12*16 +: 16] = 16'hF800; // STP
    img[13*16 +: 16] = 16'h400F; // JMP 15
    img[14*16 +: 16] = 16'h8003; // unrecognised opcode
    img[15*16 +: 16] = 16'hF800; // STP
    img[20*16 +: 16] = 16'h5816; // CALL 22
    img[21*16 +: 16] = 16'h6000; // RET
    img[22*16 +: 16] = 16'h6000; // RET
    return img;
  endfunction
  localparam logic [DEPTH*16-1:0] IMG = buildImage();

  localparam logic [9:0] S_IR   = 10'b1000000000;
  localparam logic [9:0] S_DRAM = 10'b0100000000;
  localparam logic [9:0] S_DLO  = 10'b0010000000;
  localparam logic [9:0] S_DHI  = 10'b0001000000;
  localparam logic [9:0] S_B    = 10'b0000100000;
  localparam logic [9:0] S_A    = 10'b0000010000;
  localparam logic [9:0] S_RES  = 10'b0000001000;
  localparam logic [9:0] S_ORAM = 10'b0000000100;
  localparam logic [9:0] S_ORES = 10'b0000000010;
  localparam logic [9:0] S_RW   = 10'b0000000001;

  logic clk, rst, accZero, accSign;
  logic [10:0] pcOut, marOut;
  logic [15:0] irOut;
  logic [2:0]  beatOut;
  logic irLoad, daLoadRam, daLoadLo, daLoadHi, bLoadRam, aLoadDa, resultWrite;
  logic [1:0] aluOp;
  logic outLoadRam, outLoadResult, ramWrite, halted;

  beat_seq_ctrl #(.ROM_DEPTH(DEPTH), .STACK_DEPTH(8), .PROG_IMAGE(IMG)) u0 (
    .clk(clk), .rst(rst), .accZero(accZero), .accSign(accSign),
    .pcOut(pcOut), .irOut(irOut), .marOut(marOut), .beatOut(beatOut),
    .irLoad(irLoad), .daLoadRam(daLoadRam), .daLoadLo(daLoadLo), .daLoadHi(daLoadHi),
    .bLoadRam(bLoadRam), .aLoadDa(aLoadDa), .resultWrite(resultWrite), .aluOp(aluOp),
    .outLoadRam(outLoadRam), .outLoadResult(outLoadResult), .ramWrite(ramWrite),
    .halted(halted)
  );

  typedef struct {
    string       tag;
    logic [2:0]  beat;
    logic [10:0] pc;
    logic [15:0] ir;
    logic [10:0] mar;
    logic [9:0]  strb;
    logic [1:0]  alu;
    logic        halt;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  logic monOn = 1'b0;

  logic [10:0] mPc, mMar;
  logic [15:0] mIr;
  logic [2:0]  mSp;
  logic [10:0] mStack [8];
  logic        mHalt;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic ex(string tag, int b, logic [9:0] s, logic [1:0] alu, logic h);
    item_t it;
    it.tag = tag; it.beat = 3'(b); it.pc = mPc; it.ir = mIr; it.mar = mMar;
    it.strb = s; it.alu = alu; it.halt = h;
    expQ.push_back(it);
  endtask

  // driver side: reference sequence from the requirements
  task automatic buildRun(logic z, logic s);
    logic [15:0] w;
    logic [4:0]  op;
    logic [10:0] t;
    logic [1:0]  c;
    logic [9:0]  st;
    mPc = '0; mIr = '0; mMar = '0; mSp = '0; mHalt = 1'b0;
    for (int n = 0; n < 64 && !mHalt; n++) begin
      w = IMG[mPc[4:0]*16 +: 16];
      ex(n == 0 ? "R1" : "R2", 0, S_IR, 2'd0, 1'b0);
      mIr = w; op = w[15:11]; t = w[10:0];
      case (op)
        5'b00001, 5'b00011, 5'b00110: begin // R3
          st = (op == 5'b00001) ? S_DRAM : (op == 5'b00011) ? S_ORAM : S_RW;
          ex("R3", 1, '0, 2'd0, 1'b0); mMar = t;
          ex("R3", 2, '0, 2'd0, 1'b0); mPc = mPc + 1;
          ex("R3", 3, st, 2'd0, 1'b0);
          ex("R3", 4, '0, 2'd0, 1'b0);
        end
        5'b00010, 5'b00111, 5'b01101, 5'b01110: begin // R4
          c = (op == 5'b00010) ? 2'd0 : (op == 5'b00111) ? 2'd1 :
              (op == 5'b01101) ? 2'd2 : 2'd3;
          ex("R4", 1, '0, 2'd0, 1'b0); mMar = t;
          ex("R4", 2, '0, c, 1'b0); mPc = mPc + 1;
          ex("R4", 3, S_B, c, 1'b0);
          ex("R4", 4, S_A, c, 1'b0);
          ex("R4", 5, (c >= 2'd2) ? (S_RES | S_ORES) : S_RES, c, 1'b0);
          ex("R4", 6, '0, c, 1'b0);
        end
        5'b00100, 5'b00101: begin // R5
          ex("R5", 1, '0, 2'd0, 1'b0); mPc = mPc + 1;
          ex("R5", 2, (op == 5'b00100) ? S_DLO : S_DHI, 2'd0, 1'b0);
          ex("R5", 3, '0, 2'd0, 1'b0);
        end
        5'b01000: begin // R6
          ex("R6", 1, '0, 2'd0, 1'b0); mPc = t;
          ex("R6", 2, '0, 2'd0, 1'b0);
        end
        5'b01001, 5'b01010: begin // R7
          ex("R7", 1, '0, 2'd0, 1'b0);
          if ((op == 5'b01001) ? z : s) mPc = t; else mPc = mPc + 1;
          ex("R7", 2, '0, 2'd0, 1'b0);
        end
        5'b01011: begin // R8 call
          ex("R8", 1, '0, 2'd0, 1'b0); mStack[mSp] = mPc + 1;
          ex("R8", 2, '0, 2'd0, 1'b0); mPc = t;
          ex("R8", 3, '0, 2'd0, 1'b0); mSp = mSp + 1;
        end
        5'b01100: begin // R8 return
          ex("R8", 1, '0, 2'd0, 1'b0); mSp = mSp - 1;
          ex("R8", 2, '0, 2'd0, 1'b0); mPc = mStack[mSp];
          ex("R8", 3, '0, 2'd0, 1'b0);
        end
        5'b11111: begin // R9
          ex("R9", 1, '0, 2'd0, 1'b0); mHalt = 1'b1;
          for (int k = 0; k < 4; k++) ex("R9", 0, '0, 2'd0, 1'b1);
        end
        default: begin // R10
          ex("R10", 1, '0, 2'd0, 1'b0); mPc = mPc + 1;
          ex("R10", 2, '0, 2'd0, 1'b0);
        end
      endcase
    end
  endtask

  // monitor side: pops one expected item per cycle
  initial begin
    forever begin
      item_t e;
      logic [9:0] got;
      @(negedge clk);
      #1;
      if (monOn && expQ.size() > 0) begin
        e = expQ.pop_front();
        got = {irLoad, daLoadRam, daLoadLo, daLoadHi, bLoadRam, aLoadDa,
               resultWrite, outLoadRam, outLoadResult, ramWrite};
        checks++;
        if (beatOut !== e.beat || pcOut !== e.pc || irOut !== e.ir || marOut !== e.mar ||
            got !== e.strb || aluOp !== e.alu || halted !== e.halt) begin
          errors++;
          $display("FAIL %s got beat=%0d pc=%0d ir=%h mar=%0d strb=%b alu=%0d halt=%b exp beat=%0d pc=%0d ir=%h mar=%0d strb=%b alu=%0d halt=%b",
                   e.tag, beatOut, pcOut, irOut, marOut, got, aluOp, halted,
                   e.beat, e.pc, e.ir, e.mar, e.strb, e.alu, e.halt);
        end
        checks++; // R11: accumulator written by one source at most
        if ($countones({daLoadRam, daLoadLo, daLoadHi, resultWrite}) > 1) begin
          errors++;
          $display("FAIL R11 got %b exp at most one set",
                   {daLoadRam, daLoadLo, daLoadHi, resultWrite});
        end
      end
    end
  end

  task automatic runOne(logic z, logic s);
    @(negedge clk);
    monOn = 1'b0; rst = 1'b1; accZero = z; accSign = s;
    buildRun(z, s);
    repeat (3) @(negedge clk);
    rst = 1'b0; monOn = 1'b1;
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    monOn = 1'b0;
  endtask

  initial begin
    rst = 1'b1; accZero = 1'b0; accSign = 1'b0;
    runOne(1'b1, 1'b0); // JZ taken
    runOne(1'b0, 1'b1); // JZ not taken, JN taken, unrecognised opcode
    runOne(1'b0, 1'b0); // JN not taken, halt at word 12
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule